// File: doc/BRIEF.md
# MDIO Management Master with Byte-Wide Command and Status Registers

This block lets a host read and write the 16-bit management registers of external Ethernet PHYs over the two-wire MDC/MDIO management interface, using Clause 22 frames. The host works through eight 8-bit registers on a simple byte bus. Offsets 0 to 3 hold a 32-bit command word and offsets 4 to 7 hold a 32-bit status word. In both words the lowest offset carries the least significant byte.

The host first writes the low three command bytes: the PHY address, the register address and, for a write, the data. It then writes the top byte with the go flag set. The go flag starts a frame. It stays at 1 while the frame runs and clears itself when the frame ends. After a read, the status word holds the returned data and a validity flag. MDC comes from the system clock through a parameterised divider.

A state machine runs each frame. Its states are S_IDLE, S_ARM, S_PRE, S_HDR, S_TA, S_DATA and S_DONE, with these transitions:
- S_IDLE to S_ARM on a launch.
- S_ARM to S_PRE on the next falling MDC edge.
- S_PRE to S_HDR after 32 preamble bits.
- S_HDR to S_TA after the start, opcode, PHY address and register address bits.
- S_TA to S_DATA after the two turnaround bits.
- S_DATA to S_DONE on the falling edge that follows the last data bit.
- S_DONE to S_IDLE after one cycle. In that cycle go is cleared and, for a read, the status word is loaded.

Every MDIO output change happens on a falling MDC edge, and input bits are sampled on a rising edge.

Top module: `mdio_master`

## Requirements
- R1: Command byte registers at offsets 0, 1, 2 and 3 hold command bits 7:0, 15:8, 23:16 and 31:24, and read back what was written while go is clear. Offsets 4 to 7 read status bits 7:0 to 31:24 in the same way.
- R2: Writing offset 3 with data bit 7 (command bit 31, go) set while go is clear starts a frame. Go reads 1 until the frame ends and then reads 0.
- R3: While go is set, writes to command offsets 0 to 3 are ignored, and the frame in flight is unaffected.
- R4: Each frame drives, MSB first:
  - 32 ones;
  - start 01;
  - opcode 10 for a read or 01 for a write, chosen by command bit 26 (1 selects a write);
  - PHY address from command bits 25:21;
  - register address from command bits 20:16.
- R5: In a write frame, after the register address the block drives turnaround 10 and then command bits 15:0, MSB first. mdio_oe stays high for all 64 bits.
- R6: In a read frame, mdio_oe is low for the two turnaround bits and the 16 data bits. The 16 sampled bits, MSB first, appear in status bits 15:0 after completion.
- R7: After a read, status bit 31 is 1 if mdio_i was low at the second turnaround bit (frame bit 47, counting the first preamble bit as 0), and 0 otherwise. Status bits 30:16 are 0.
- R8: MDC has a period of 2*MDC_HALF system clocks. mdio_o and mdio_oe change only on system edges where MDC falls, and mdio_i is sampled where MDC rises.
- R9: Writes to status offsets 4 to 7 are ignored, and a completed write frame leaves the status word unchanged.
- R10: After reset the command and status words read 0, mdc is 0 and mdio_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Byte register write strobe |
| reg_addr | input | 3 | Byte register offset (0-3 command, 4-7 status) |
| reg_wdata | input | 8 | Byte write data |
| reg_rdata | output | 8 | Byte read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | Management data in from the pad |
| mdio_o | output | 1 | Management data out to the pad |
| mdio_oe | output | 1 | Output enable for the MDIO pad driver |

## Verification
The bench builds the block with MDC_HALF = 3. This odd divider exercises a counter limit that is not a power of two and gives a 6-cycle MDC period, which keeps each frame short. With that period the bench can sweep every one of the 32 PHY addresses for both reads and writes, each with a different register address and data pattern. A bench PHY model answers reads and stays silent at two addresses, which brings the failed-read flag and the all-ones idle bus into reach. The bench also checks the rejected command writes during a frame, the ignored status writes and the measured MDC period.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int GO_BIT     = 31;
    localparam int WR_BIT     = 26;
    localparam int PHY_LSB    = 21;
    localparam int REG_LSB    = 16;
    localparam int PRE_BITS   = 32;
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_PRE,
        S_HDR,
        S_TA,
        S_DATA,
        S_DONE
    } mdio_state_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick     = (cnt == CW'(MDC_HALF - 1));
    assign rise_stb = tick & ~mdc;
    assign fall_stb = tick & mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8
    mdc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> mdc);
    // R8
    mdc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !mdc);
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              start,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] phy_ad,
    input  logic [ADDR_W-1:0] reg_ad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ok
);
    mdio_state_e       state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  idx_nx;
    logic              busy;
    logic              last;
    logic [WORD_W-1:0] tx;
    logic              wr_q;
    logic [DATA_W-1:0] rx;
    logic              ta_ok;

    assign idx_nx = idx + 1'b1;
    assign busy   = (state == S_PRE) || (state == S_HDR) ||
                    (state == S_TA) || (state == S_DATA);
    assign last   = (idx == IDX_W'(FRAME_BITS - 1));

    function automatic mdio_state_e phase_of(input logic [IDX_W-1:0] i);
        if (int'(i) < PRE_BITS)        return S_PRE;
        else if (int'(i) < TA_FIRST)   return S_HDR;
        else if (int'(i) < DATA_FIRST) return S_TA;
        else                           return S_DATA;
    endfunction

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = S_ARM;
            S_ARM:  if (fall_stb) state_nx = S_PRE;
            S_PRE, S_HDR, S_TA, S_DATA:
                if (fall_stb) state_nx = last ? S_DONE : phase_of(idx_nx);
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register and frame bit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (state == S_ARM && fall_stb) idx <= '0;
            else if (busy && fall_stb)      idx <= idx_nx;
        end
    end

    // Outputs, shift registers and sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            tx      <= '0;
            wr_q    <= 1'b0;
            rx      <= '0;
            ta_ok   <= 1'b0;
        end else begin
            if (state == S_IDLE && start) begin
                tx    <= {2'b01, is_wr ? 2'b01 : 2'b10, phy_ad, reg_ad,
                          2'b10, is_wr ? wdata : {DATA_W{1'b0}}};
                wr_q  <= is_wr;
                ta_ok <= 1'b0;
            end
            if (fall_stb) begin
                if (state == S_ARM) begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b1;
                end else if (busy) begin
                    if (last) begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b0;
                    end else begin
                        if (int'(idx_nx) >= PRE_BITS) begin
                            mdio_o <= tx[WORD_W-1];
                            tx     <= tx << 1;
                        end
                        mdio_oe <= wr_q || (int'(idx_nx) < TA_FIRST);
                    end
                end
            end
            if (rise_stb) begin
                if (state == S_TA && idx == IDX_W'(TA_FIRST + 1))
                    ta_ok <= !mdio_i;
                if (state == S_DATA)
                    rx <= {rx[DATA_W-2:0], mdio_i};
            end
        end
    end

    assign done    = (state == S_DONE);
    assign rd_data = rx;
    assign rd_ok   = ta_ok;

    // R8
    out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fall_stb) |-> ($stable(mdio_o) && $stable(mdio_oe)));
    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_TA || state == S_DATA) && !wr_q) |-> !mdio_oe);
    // R5
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_TA || state == S_DATA) && wr_q) |-> mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic [WORD_W-1:0] cmd_q;
    logic [WORD_W-1:0] sts_q;
    logic [WORD_W-1:0] launch_word;
    logic              rise_stb, fall_stb;
    logic              start, done, rd_ok;
    logic [DATA_W-1:0] rd_data;
    logic              cmd_wr;

    assign cmd_wr      = reg_wr && !reg_addr[2] && !cmd_q[GO_BIT];
    assign start       = cmd_wr && (reg_addr[1:0] == 2'd3) && reg_wdata[7];
    assign launch_word = {reg_wdata, cmd_q[WORD_W-BYTE_W-1:0]};

    mdio_clkgen #(.MDC_HALF(MDC_HALF)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .start    (start),
        .is_wr    (launch_word[WR_BIT]),
        .phy_ad   (launch_word[PHY_LSB +: ADDR_W]),
        .reg_ad   (launch_word[REG_LSB +: ADDR_W]),
        .wdata    (launch_word[DATA_W-1:0]),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_data  (rd_data),
        .rd_ok    (rd_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            sts_q <= '0;
        end else begin
            if (cmd_wr)
                cmd_q[reg_addr[1:0]*BYTE_W +: BYTE_W] <= reg_wdata;
            if (done) begin
                cmd_q[GO_BIT] <= 1'b0;
                if (!cmd_q[WR_BIT])
                    sts_q <= {rd_ok, {(WORD_W-DATA_W-1){1'b0}}, rd_data};
            end
        end
    end

    assign reg_rdata = reg_addr[2] ? sts_q[reg_addr[1:0]*BYTE_W +: BYTE_W]
                                   : cmd_q[reg_addr[1:0]*BYTE_W +: BYTE_W];

    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q[GO_BIT] && !done) |=> $stable(cmd_q));
    // R2
    go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_q[GO_BIT]) |-> $past(done));
    // R9
    sts_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done) |-> $stable(sts_q));
    // R9
    sts_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done) && $past(cmd_q[WR_BIT])) |-> $stable(sts_q));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int HALF = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       mdc, mdio_o, mdio_oe, mdio_i;

    int errors = 0;
    int checks = 0;

    // bench PHY model
    int          pos = 64;
    logic [63:0] rec_o, rec_oe;
    logic        phy_here = 1'b1;
    logic [15:0] phy_resp = 16'h0;
    logic        phy_bit = 1'b1;

    always #4 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_bit;

    mdio_master #(.MDC_HALF(HALF)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always @(posedge mdc) begin
        if (pos < 64 && !(pos == 0 && !mdio_oe)) begin
            rec_o[pos]  = mdio_o;
            rec_oe[pos] = mdio_oe;
            pos = pos + 1;
        end
    end

    always @(negedge mdc) begin
        if (pos == 47)                   phy_bit = !phy_here;
        else if (pos >= 48 && pos <= 63) phy_bit = phy_here ? phy_resp[63-pos] : 1'b1;
        else                             phy_bit = 1'b1;
    end

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_byte(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_word(input logic hi, output logic [31:0] w);
        for (int b = 0; b < 4; b++) begin
            logic [7:0] d;
            rd_byte({hi, 2'(b)}, d);
            w[b*8 +: 8] = d;
        end
    endtask

    logic [31:0] exp_sts = 32'h0;

    task automatic run_frame(input logic wr, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] data,
                             input logic present, input logic poke);
        logic [31:0] cmd, w, got;
        logic [63:0] exp_o, exp_oe, mask;
        logic [7:0]  d;
        int          n;
        cmd = {1'b1, 4'b0, wr, phy, rg, data};
        phy_here = present; phy_resp = data;
        pos = 0;
        wr_byte(3'd0, cmd[7:0]);
        wr_byte(3'd1, cmd[15:8]);
        wr_byte(3'd2, cmd[23:16]);
        wr_byte(3'd3, cmd[31:24]);
        rd_byte(3'd3, d);
        check("R2 go reads 1 while busy", 64'(d[7]), 64'd1);
        if (poke) begin
            wr_byte(3'd0, ~cmd[7:0]);
            wr_byte(3'd3, 8'h00);
            wr_byte(3'd2, ~cmd[23:16]);
        end
        n = 0;
        d = 8'h80;
        while (d[7] && n < 2000) begin
            rd_byte(3'd3, d);
            n++;
        end
        check("R2 go clears at completion", 64'(d[7]), 64'd0);
        w = {2'b01, wr ? 2'b01 : 2'b10, phy, rg, 2'b10, data};
        for (int i = 0; i < 64; i++) begin
            exp_o[i]  = (i < 32) ? 1'b1 : w[63-i];
            exp_oe[i] = wr || (i < 46);
            mask[i]   = exp_oe[i];
        end
        check(wr ? "R4/R5 write frame bits" : "R4 read header bits",
              rec_o & mask, exp_o & mask);
        check(wr ? "R5 oe high whole frame" : "R6 oe released in TA/data",
              rec_oe, exp_oe);
        if (!wr) exp_sts = {present, 15'b0, present ? data : 16'hFFFF};
        rd_word(1'b1, got);
        check(wr ? "R9 status kept after write" : "R6/R7 read status",
              64'(got), 64'(exp_sts));
        if (poke) begin
            rd_word(1'b0, got);
            check("R3 command writes ignored while busy",
                  64'(got), 64'({1'b0, cmd[30:0]}));
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] got;
        int t0, t1;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 mdc/oe in reset", {62'b0, mdc, mdio_oe}, 64'd0);
        rst_n = 1'b1;
        rd_word(1'b0, got);
        check("R10 command after reset", 64'(got), 64'd0);
        rd_word(1'b1, got);
        check("R10 status after reset", 64'(got), 64'd0);
        // R1 byte map readback
        wr_byte(3'd0, 8'h12); wr_byte(3'd1, 8'h34);
        wr_byte(3'd2, 8'h56); wr_byte(3'd3, 8'h78);
        rd_word(1'b0, got);
        check("R1 command byte map", 64'(got), 64'h78563412);
        // R8 mdc period
        @(posedge mdc); t0 = $time;
        @(posedge mdc); t1 = $time;
        check("R8 mdc period", 64'((t1 - t0) / 8), 64'(2 * HALF));
        // R9 status writes ignored
        for (int b = 4; b < 8; b++) wr_byte(3'(b), 8'h55);
        rd_word(1'b1, got);
        check("R9 status write ignored", 64'(got), 64'd0);
        // read sweep over every PHY address
        for (int p = 0; p < 32; p++)
            run_frame(1'b0, 5'(p), 5'((p * 7 + 3) % 32),
                      16'((p * 16'h0913) ^ 16'hA5C3),
                      (p != 5 && p != 20), (p == 9));
        // write sweep over every PHY address
        for (int p = 0; p < 32; p++)
            run_frame(1'b1, 5'(p), 5'((p * 11 + 1) % 32),
                      16'((p * 16'h2D51) ^ 16'h3C96), 1'b1, (p == 17));
        finish_run();
    end
endmodule